// File: doc/BRIEF.md
# Weak-Indication Dual-Rail Ripple Adder

This block adds two 32-bit operands and a carry-in. Every one of these values travels on two wires per bit, and so do the sum and the carry-out. Data arrives in waves. A valid codeword is followed by an all-low spacer, then by the next codeword. The adder never depends on when the operand bits arrive. Each sum bit is only marked valid once the three inputs of its cell are valid, and a completion flag reports when the whole result is present or has fully cleared.

Each cell divides the work between its two outputs. The carry output is built so that it can resolve early. When both operand bits agree, the carry no longer waits for the incoming carry. When the operand bits return to spacer, the carry clears without waiting for the ripple. The sum output carries the indication duty alone.

Each sum rail is held in a clocked hysteresis element. It is set when all three cell inputs are valid and cleared when all three are spacer. A second hysteresis element of the same kind forms the completion flag over the 33 output pairs. The clocked model stands in for a self-timed Muller element. A consumer waits for `done` to rise, takes the result, then withdraws its inputs and waits for `done` to fall. This plain level handshake replaces valid/ready, because the wave protocol itself provides the flow control.

Top module: `wi_ripple_adder`

## Requirements
- R1: Each pair is {one rail, zero rail}. A 1 is (1,0), a 0 is (0,1), and the spacer is (0,0). With legal inputs, no output pair ever has both rails high.
- R2: After a wave with every input valid and `done` high, {cout, sum} decodes to A + B + cin as a 33-bit value.
- R3: When the operand bits of a cell are valid and equal, its carry output resolves to that bit's value without a valid carry-in. For the top bit this is visible combinationally on the cout pair.
- R4: A sum pair becomes valid only at a clock edge where its operand bits and its carry-in are all valid. If the carry-in of bit 0 is spacer, sum bit 0 stays spacer.
- R5: A valid sum pair returns to spacer only at a clock edge where its operand bits and its carry-in are all spacer.
- R6: When every operand bit is spacer, the cout pair is spacer in the same cycle, whatever the carry-in holds.
- R7: `done` rises one clock after all 32 sum pairs are valid and cout is valid. It is low while any of them is spacer.
- R8: Once high, `done` falls only one clock after all sum rails and both cout rails are low, and it stays high in between.
- R9: While rst_n is low, every sum rail and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hysteresis elements |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a_one | input | 32 | Operand A, one rails |
| op_a_zero | input | 32 | Operand A, zero rails |
| op_b_one | input | 32 | Operand B, one rails |
| op_b_zero | input | 32 | Operand B, zero rails |
| cin_one | input | 1 | Carry-in, one rail |
| cin_zero | input | 1 | Carry-in, zero rail |
| sum_one | output | 32 | Sum, one rails |
| sum_zero | output | 32 | Sum, zero rails |
| cout_one | output | 1 | Carry-out, one rail |
| cout_zero | output | 1 | Carry-out, zero rail |
| done | output | 1 | Completion: high when all result pairs are valid, low after all are spacer |

## Verification
The checker assumes that no input pair ever has both rails high. It also assumes that inputs change only between clock edges, so the combinational carry chain is settled when the clock samples it. The bench drives every pair from a value and a validity flag, which cannot yield both rails high. It counts a check on every drive to confirm this. All stimulus changes on the falling edge, so nothing moves near a rising edge. Partial waves, where the operands are valid while the carry-in is spacer or the other way round, exercise the ordering rules without ever forming an illegal code.

// File: rtl/wi_dr_pkg.sv
package wi_dr_pkg;
  typedef struct packed {
    logic one;
    logic zero;
  } rail_t;

  function automatic logic pair_valid(input rail_t p);
    return p.one ^ p.zero;
  endfunction

  function automatic logic pair_spacer(input rail_t p);
    return ~(p.one | p.zero);
  endfunction
endpackage

// File: rtl/wi_fa_cell.sv
module wi_fa_cell
  import wi_dr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  rail_t a,
  input  rail_t b,
  input  rail_t ci,
  output rail_t co,
  output rail_t s
);
  logic set_one, set_zero, all_gone;

  // Carry: disjoint product terms; equal operands decide alone, and every
  // term contains an operand rail so that spacer operands clear it at once.
  always_comb begin
    co.one  = (a.one & b.one)   | (a.one & b.zero & ci.one)  | (a.zero & b.one & ci.one);
    co.zero = (a.zero & b.zero) | (a.one & b.zero & ci.zero) | (a.zero & b.one & ci.zero);
  end

  // Sum minterms need all three inputs.
  always_comb begin
    set_one  = (a.one & b.zero & ci.zero) | (a.zero & b.one & ci.zero) |
               (a.zero & b.zero & ci.one) | (a.one & b.one & ci.one);
    set_zero = (a.zero & b.zero & ci.zero) | (a.one & b.one & ci.zero) |
               (a.one & b.zero & ci.one)   | (a.zero & b.one & ci.one);
    all_gone = pair_spacer(a) & pair_spacer(b) & pair_spacer(ci);
  end

  // Hysteresis element per sum rail.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s <= '0;
    end else if (set_one | set_zero) begin
      s.one  <= set_one;
      s.zero <= set_zero;
    end else if (all_gone) begin
      s <= '0;
    end
  end
endmodule

// File: rtl/wi_done_det.sv
module wi_done_det #(
  parameter int unsigned N = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pv,
  input  logic [N-1:0] pany,
  output logic         done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (&pv)      done <= 1'b1;
    else if (~|pany)   done <= 1'b0;
  end
endmodule

// File: rtl/wi_ripple_adder.sv
module wi_ripple_adder
  import wi_dr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a_one,
  input  logic [W-1:0] op_a_zero,
  input  logic [W-1:0] op_b_one,
  input  logic [W-1:0] op_b_zero,
  input  logic         cin_one,
  input  logic         cin_zero,
  output logic [W-1:0] sum_one,
  output logic [W-1:0] sum_zero,
  output logic         cout_one,
  output logic         cout_zero,
  output logic         done
);
  localparam int unsigned NP = W + 1;

  logic [W:0]    cy_one, cy_zero;
  logic [NP-1:0] res_v, res_any;

  assign cy_one[0]  = cin_one;
  assign cy_zero[0] = cin_zero;

  for (genvar i = 0; i < W; i++) begin : g_bit
    rail_t ra, rb, rc, rco, rs;
    assign ra = '{one: op_a_one[i], zero: op_a_zero[i]};
    assign rb = '{one: op_b_one[i], zero: op_b_zero[i]};
    assign rc = '{one: cy_one[i],   zero: cy_zero[i]};

    wi_fa_cell u_cell (
      .clk(clk), .rst_n(rst_n), .a(ra), .b(rb), .ci(rc), .co(rco), .s(rs)
    );

    assign cy_one[i+1]  = rco.one;
    assign cy_zero[i+1] = rco.zero;
    assign sum_one[i]   = rs.one;
    assign sum_zero[i]  = rs.zero;
    assign res_v[i]     = rs.one ^ rs.zero;
    assign res_any[i]   = rs.one | rs.zero;
  end

  assign cout_one    = cy_one[W];
  assign cout_zero   = cy_zero[W];
  assign res_v[W]    = cout_one ^ cout_zero;
  assign res_any[W]  = cout_one | cout_zero;

  wi_done_det #(.N(NP)) u_done (
    .clk(clk), .rst_n(rst_n), .pv(res_v), .pany(res_any), .done(done)
  );
endmodule

// File: rtl/wi_adder_checker.sv
module wi_adder_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a_one,
  input logic [W-1:0] op_a_zero,
  input logic [W-1:0] op_b_one,
  input logic [W-1:0] op_b_zero,
  input logic [W:0]   cy_one,
  input logic [W:0]   cy_zero,
  input logic [W-1:0] sum_one,
  input logic [W-1:0] sum_zero,
  input logic         cout_one,
  input logic         cout_zero,
  input logic         done
);
  logic [W-1:0] sv, in_v, in_any;
  logic         ops_gone;

  always_comb begin
    sv       = sum_one ^ sum_zero;
    in_v     = (op_a_one ^ op_a_zero) & (op_b_one ^ op_b_zero) & (cy_one[W-1:0] ^ cy_zero[W-1:0]);
    in_any   = op_a_one | op_a_zero | op_b_one | op_b_zero | cy_one[W-1:0] | cy_zero[W-1:0];
    ops_gone = ~|(op_a_one | op_a_zero | op_b_one | op_b_zero);
  end

  assert_one_hot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((sum_one & sum_zero) == '0) && !(cout_one && cout_zero));

  assert_top_early_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a_one[W-1] && op_b_one[W-1]) |-> (cout_one && !cout_zero));

  assert_top_early_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a_zero[W-1] && op_b_zero[W-1]) |-> (cout_zero && !cout_one));

  assert_sum_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sv & ~$past(sv)) & ~$past(in_v)) == '0);

  assert_sum_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sv & $past(sv)) & $past(in_any)) == '0);

  assert_carry_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ops_gone |-> (!cout_one && !cout_zero));

  assert_done_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past((&sv) && (cout_one ^ cout_zero)));

  assert_done_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(((sum_one | sum_zero) == '0) && !cout_one && !cout_zero));
endmodule

bind wi_ripple_adder wi_adder_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .op_a_one(op_a_one), .op_a_zero(op_a_zero),
  .op_b_one(op_b_one), .op_b_zero(op_b_zero),
  .cy_one(cy_one), .cy_zero(cy_zero),
  .sum_one(sum_one), .sum_zero(sum_zero),
  .cout_one(cout_one), .cout_zero(cout_zero),
  .done(done)
);

// File: tb/wi_ripple_adder_tb_top.sv
module wi_ripple_adder_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_one = '0, a_zero = '0, b_one = '0, b_zero = '0;
  logic         c_one = 1'b0, c_zero = 1'b0;
  logic [W-1:0] sum_one, sum_zero;
  logic         cout_one, cout_zero, done;

  int checks = 0;
  int errors = 0;
  logic [W:0] exp_q[$];

  always #10 clk = ~clk;

  wi_ripple_adder #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .op_a_one(a_one), .op_a_zero(a_zero), .op_b_one(b_one), .op_b_zero(b_zero),
    .cin_one(c_one), .cin_zero(c_zero),
    .sum_one(sum_one), .sum_zero(sum_zero),
    .cout_one(cout_one), .cout_zero(cout_zero), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                       input bit av, input bit bv, input bit cv);
    a_one  = av ? a  : '0;  a_zero = av ? ~a : '0;
    b_one  = bv ? b  : '0;  b_zero = bv ? ~b : '0;
    c_one  = cv ? c  : 1'b0; c_zero = cv ? ~c : 1'b0;
    // R1: stimulus must never hold an illegal both-high pair
    chk(((a_one & a_zero) | (b_one & b_zero)) == '0 && !(c_one && c_zero),
        "R1 illegal input pair", {31'd0, c_one & c_zero, (a_one & a_zero) | (b_one & b_zero)}, 64'd0);
  endtask

  task automatic apply_wave(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    exp_q.push_back({1'b0, a} + {1'b0, b} + {{W{1'b0}}, c});
    @(negedge clk);
    drive(a, b, c, 1, 1, 1);
    repeat (2) @(negedge clk);
    chk(done === 1'b1, "R7 done after valid wave", {63'd0, done}, 64'd1);
    drive('0, '0, 1'b0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk(done === 1'b0, "R8 done after spacer", {63'd0, done}, 64'd0);
    chk((sum_one | sum_zero) == '0, "R8 sums spacer", {32'd0, sum_one | sum_zero}, 64'd0);
  endtask

  // Scoreboard monitor: pops on each rise of done; also watches sum ordering.
  initial begin : monitor
    logic         prev_done = 1'b0;
    logic [W-1:0] prev_sv = '0;
    forever begin
      @(posedge clk);
      #5;
      if (rst_n) begin
        logic [W-1:0] sv, inv, rising;
        sv  = sum_one ^ sum_zero;
        inv = (a_one ^ a_zero) & (b_one ^ b_zero);
        rising = sv & ~prev_sv;
        // R4: a newly valid sum needs valid operand bits (bit 0 also its carry-in)
        if (rising != '0)
          chk(((rising & ~inv) == '0) && !(rising[0] && !(c_one ^ c_zero)),
              "R4 sum before inputs", {32'd0, rising}, {32'd0, rising & inv});
        if (done && !prev_done) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected result", {31'd0, cout_one, sum_one}, 64'd0);
          end else begin
            logic [W:0] e;
            e = exp_q.pop_front();
            chk(sv == '1 && (cout_one ^ cout_zero), "R1 result pairs valid",
                {31'd0, cout_one ^ cout_zero, sv}, {31'd1, {W{1'b1}}});
            chk({cout_one, sum_one} == e, "R2 sum value", {31'd0, cout_one, sum_one}, {31'd0, e});
          end
        end
        prev_sv   = sv;
        prev_done = done;
      end
    end
  end

  initial begin : watchdog
    #(20ns * 100000);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed;
    seed = 32'h1234_abcd;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(done === 1'b0, "R9 done in reset", {63'd0, done}, 64'd0);
    chk((sum_one | sum_zero) == '0, "R9 sums in reset", {32'd0, sum_one | sum_zero}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 / R7 / R8: full waves
    apply_wave(32'h0, 32'h0, 1'b0);
    apply_wave(32'hFFFF_FFFF, 32'h1, 1'b0);
    apply_wave(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    apply_wave(32'h8000_0000, 32'h8000_0000, 1'b0);
    apply_wave(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    apply_wave(32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] ra, rb;
      seed = seed * 32'd1664525 + 32'd1013904223; ra = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; rb = seed;
      apply_wave(ra, rb, seed[16]);
    end

    // R3: equal top operand bits (1) resolve cout with carry-in spacer
    @(negedge clk);
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, 1, 1, 0);
    #1;
    chk(cout_one && !cout_zero, "R3 early carry one", {62'd0, cout_one, cout_zero}, 64'h2);
    repeat (2) @(negedge clk);
    // R4: bit 0 sum waits for carry-in
    chk(!(sum_one[0] | sum_zero[0]), "R4 sum0 waits for cin", {62'd0, sum_one[0], sum_zero[0]}, 64'd0);
    chk(done === 1'b0, "R7 done low while sum0 spacer", {63'd0, done}, 64'd0);
    exp_q.push_back({1'b0, 32'h8000_0000} + {1'b0, 32'h8000_0000} + 33'd1);
    drive(32'h8000_0000, 32'h8000_0000, 1'b1, 1, 1, 1);
    repeat (2) @(negedge clk);
    chk(done === 1'b1, "R7 done after cin arrives", {63'd0, done}, 64'd1);

    // R6: operands to spacer, carry-in still valid: cout clears at once
    drive('0, '0, 1'b1, 0, 0, 1);
    #1;
    chk(!cout_one && !cout_zero, "R6 cout constant-time reset", {62'd0, cout_one, cout_zero}, 64'd0);
    repeat (2) @(negedge clk);
    // R5: sum bit 0 holds while its carry-in is valid; R8: done holds
    chk(sum_one[0] && !sum_zero[0], "R5 sum0 holds", {62'd0, sum_one[0], sum_zero[0]}, 64'h2);
    chk((sum_one[W-1:1] | sum_zero[W-1:1]) == '0, "R5 upper sums spacer",
        {33'd0, sum_one[W-1:1] | sum_zero[W-1:1]}, 64'd0);
    chk(done === 1'b1, "R8 done holds on partial spacer", {63'd0, done}, 64'd1);
    drive('0, '0, 1'b0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk(done === 1'b0, "R8 done falls after full spacer", {63'd0, done}, 64'd0);

    // R3: equal top operand bits (0) resolve cout to zero
    drive(32'h0000_0001, 32'h0000_0000, 1'b0, 1, 1, 0);
    #1;
    chk(cout_zero && !cout_one, "R3 early carry zero", {62'd0, cout_one, cout_zero}, 64'h1);
    repeat (2) @(negedge clk);
    chk(!(sum_one[0] | sum_zero[0]), "R4 sum0 spacer without cin", {62'd0, sum_one[0], sum_zero[0]}, 64'd0);
    drive('0, '0, 1'b0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk((sum_one | sum_zero) == '0, "R5 sums clear after spacer", {32'd0, sum_one | sum_zero}, 64'd0);
    chk(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule